// File: doc/BRIEF.md
# MOESI Line-State Coherence Controller

This block holds the coherence state of every line of one private cache in a small shared-memory multiprocessor. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. The state is stored as three bits (valid, dirty, shared), and each line also has one reservation bit for load-reserved and store-conditional pairs. The cache sends the controller one local operation per cycle: load, store, load-reserved, store-conditional or evict. The bus snooper sends it at most one remote event per cycle: a read or a write/invalidate from another cache.

From these inputs the controller computes each line's next state. It raises a bus broadcast request, either a read for a fill or an invalidate to claim ownership. It raises a supply request when this cache must answer another cache instead of memory. It raises a writeback request when dirty data leaves the cache. It also returns the line's new state and, for a store-conditional, whether it passed. Data storage, arbitration and memory are outside the block. Every result is registered and appears one cycle after the request.

Top module: `moesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid with no reservation, and every output is low.
- R2: A load or load-reserved to an Invalid line raises `bc_req` with `bc_kind`=0 (read). The line fills to Exclusive when `lq_peer_has` is 0 and to Shared when it is 1. A load-reserved also sets the line's reservation. A load to a valid line changes nothing and raises no broadcast.
- R3: A store to an Exclusive or Modified line leaves the line Modified and raises no broadcast.
- R4: A store to a Shared, Owned or Invalid line raises `bc_req` with `bc_kind`=1 (invalidate), and the line becomes Modified.
- R5: Evicting a Modified or Owned line raises `wb_req`. Evicting an Exclusive, Shared or Invalid line raises none. Every evicted line ends Invalid with its reservation cleared.
- R6: A remote read turns Modified into Owned and Exclusive into Shared. It raises `sup_req` for a Modified or Owned line and for no other state.
- R7: A remote write/invalidate turns any valid line Invalid and clears its reservation. It raises `sup_req` when the line was Modified or Owned.
- R8: A store-conditional passes (`rsp_sc_ok`=1) only on a valid line that holds a reservation. On a pass the line becomes Modified and the reservation clears, and an invalidate broadcast is raised only if the line was Shared or Owned. On a fail nothing changes and no broadcast is raised.
- R9: `rsp_state` is {valid, dirty, shared}: Modified 110, Owned 111, Exclusive 100, Shared 101, Invalid 000.
- R10: Every output of a request sampled at clock edge t appears right after edge t and lasts one cycle. `rsp_state` gives the state after the request.
- R11: When a remote event and a local operation hit the same line in one cycle, the remote event is applied first and the local operation acts on its result.
- R12: Operation codes 5 to 7 change no state and raise no bus action. They still return `rsp_valid` with the current state. Codes: 0 load, 1 store, 2 load-reserved, 3 store-conditional, 4 evict. Remote code: 0 read, 1 write/invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lq_valid | input | 1 | Local operation present |
| lq_op | input | 3 | Local operation code |
| lq_idx | input | IDX_W | Line index of local operation |
| lq_peer_has | input | 1 | Snoop response for a fill: another cache holds the line |
| sn_valid | input | 1 | Remote event present |
| sn_op | input | 1 | Remote event kind (0 read, 1 write/invalidate) |
| sn_idx | input | IDX_W | Line index of remote event |
| rsp_valid | output | 1 | Local operation result valid |
| rsp_state | output | 3 | Line state after the operation {valid, dirty, shared} |
| rsp_sc_ok | output | 1 | Store-conditional passed |
| bc_req | output | 1 | Bus broadcast request |
| bc_kind | output | 1 | Broadcast kind (0 read, 1 invalidate) |
| bc_idx | output | IDX_W | Broadcast line index |
| sup_req | output | 1 | Supply data to the requesting cache |
| sup_idx | output | IDX_W | Supplied line index |
| wb_req | output | 1 | Write the line back to memory |
| wb_idx | output | IDX_W | Writeback line index |

## Verification
Every result of this block is due exactly one cycle after its request: response, pass flag, broadcast, supply and writeback. The bench drives each request on a falling edge and advances its reference model at that same moment. It then compares every output against the model on the next falling edge. That edge falls after exactly one register stage, so a result that is one cycle early or late shows up as a mismatch. The directed phases and the random phase both feed the same cycle-by-cycle comparison. The random phase draws indices from a narrow range, so same-line collisions between remote and local requests happen often.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef struct packed {
    logic v;
    logic d;
    logic s;
  } line_st_t;

  localparam line_st_t ST_I = 3'b000;
  localparam line_st_t ST_E = 3'b100;
  localparam line_st_t ST_S = 3'b101;
  localparam line_st_t ST_M = 3'b110;
  localparam line_st_t ST_O = 3'b111;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_LR    = 3'd2;
  localparam logic [2:0] OP_SC    = 3'd3;
  localparam logic [2:0] OP_EVICT = 3'd4;

  localparam logic SN_READ  = 1'b0;
  localparam logic SN_WRITE = 1'b1;

  localparam logic BC_READ = 1'b0;
  localparam logic BC_INV  = 1'b1;
endpackage

// File: rtl/moesi_snoop_next.sv
module moesi_snoop_next
  import moesi_pkg::*;
(
  input  logic     act,
  input  logic     op,
  input  line_st_t cur,
  input  logic     cur_res,
  output line_st_t nxt,
  output logic     nxt_res,
  output logic     supply
);
  always_comb begin
    nxt     = cur;
    nxt_res = cur_res;
    supply  = 1'b0;
    if (act && cur.v) begin
      if (op == SN_WRITE) begin
        supply  = cur.d;
        nxt     = ST_I;
        nxt_res = 1'b0;
      end else begin
        supply = cur.d;
        nxt.s  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/moesi_local_next.sv
module moesi_local_next
  import moesi_pkg::*;
(
  input  logic       act,
  input  logic [2:0] op,
  input  logic       peer_has,
  input  line_st_t   cur,
  input  logic       cur_res,
  output line_st_t   nxt,
  output logic       nxt_res,
  output logic       bc,
  output logic       bc_kind,
  output logic       wb,
  output logic       sc_ok
);
  always_comb begin
    nxt     = cur;
    nxt_res = cur_res;
    bc      = 1'b0;
    bc_kind = BC_READ;
    wb      = 1'b0;
    sc_ok   = 1'b0;
    if (act) begin
      case (op)
        OP_LOAD, OP_LR: begin
          if (!cur.v) begin
            nxt     = peer_has ? ST_S : ST_E;
            bc      = 1'b1;
            bc_kind = BC_READ;
          end
          if (op == OP_LR) nxt_res = 1'b1;
        end
        OP_STORE: begin
          nxt = ST_M;
          if (!cur.v || cur.s) begin
            bc      = 1'b1;
            bc_kind = BC_INV;
          end
        end
        OP_SC: begin
          if (cur.v && cur_res) begin
            sc_ok   = 1'b1;
            nxt     = ST_M;
            nxt_res = 1'b0;
            if (cur.s) begin
              bc      = 1'b1;
              bc_kind = BC_INV;
            end
          end
        end
        OP_EVICT: begin
          wb      = cur.v && cur.d;
          nxt     = ST_I;
          nxt_res = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output line_st_t         ra_st,
  output logic             ra_res,
  input  logic [IDX_W-1:0] rb_idx,
  output line_st_t         rb_st,
  output logic             rb_res,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  line_st_t         wa_st,
  input  logic             wa_res,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_t         wb_st,
  input  logic             wb_res
);
  line_st_t st_q  [N_LINES];
  logic     res_q [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]  <= ST_I;
        res_q[g] <= 1'b0;
      end else if (wa_en && wa_idx == IDX_W'(g)) begin
        st_q[g]  <= wa_st;
        res_q[g] <= wa_res;
      end else if (wb_en && wb_idx == IDX_W'(g)) begin
        st_q[g]  <= wb_st;
        res_q[g] <= wb_res;
      end
    end

    // a reservation may only sit on a valid line (R8)
    assert_res_on_valid_R8: assert property (@(posedge clk) disable iff (rst)
      res_q[g] |-> st_q[g].v);
    // invalid lines keep their other bits clear (R9)
    assert_inv_clean_line_R9: assert property (@(posedge clk) disable iff (rst)
      !st_q[g].v |-> (st_q[g].d == 1'b0 && st_q[g].s == 1'b0));
  end

  assign ra_st  = st_q[ra_idx];
  assign ra_res = res_q[ra_idx];
  assign rb_st  = st_q[rb_idx];
  assign rb_res = res_q[rb_idx];
endmodule

// File: rtl/moesi_coherence_ctrl.sv
module moesi_coherence_ctrl
  import moesi_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lq_valid,
  input  logic [2:0]       lq_op,
  input  logic [IDX_W-1:0] lq_idx,
  input  logic             lq_peer_has,
  input  logic             sn_valid,
  input  logic             sn_op,
  input  logic [IDX_W-1:0] sn_idx,
  output logic             rsp_valid,
  output logic [2:0]       rsp_state,
  output logic             rsp_sc_ok,
  output logic             bc_req,
  output logic             bc_kind,
  output logic [IDX_W-1:0] bc_idx,
  output logic             sup_req,
  output logic [IDX_W-1:0] sup_idx,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx
);
  line_st_t s_cur, s_nxt, b_cur, l_cur, l_nxt;
  logic     s_res, s_res_n, b_res, l_res, l_res_n;
  logic     s_sup, l_bc, l_bc_kind, l_wb, l_sc_ok;
  logic     collide;

  moesi_line_store #(.N_LINES(N_LINES)) i_store (
    .clk    (clk),
    .rst    (rst),
    .ra_idx (sn_idx),
    .ra_st  (s_cur),
    .ra_res (s_res),
    .rb_idx (lq_idx),
    .rb_st  (b_cur),
    .rb_res (b_res),
    .wa_en  (lq_valid),
    .wa_idx (lq_idx),
    .wa_st  (l_nxt),
    .wa_res (l_res_n),
    .wb_en  (sn_valid),
    .wb_idx (sn_idx),
    .wb_st  (s_nxt),
    .wb_res (s_res_n)
  );

  moesi_snoop_next i_snoop (
    .act     (sn_valid),
    .op      (sn_op),
    .cur     (s_cur),
    .cur_res (s_res),
    .nxt     (s_nxt),
    .nxt_res (s_res_n),
    .supply  (s_sup)
  );

  // remote event first: a local op on the same line sees the snooped result
  assign collide = sn_valid && lq_valid && (sn_idx == lq_idx);
  assign l_cur   = collide ? s_nxt   : b_cur;
  assign l_res   = collide ? s_res_n : b_res;

  moesi_local_next i_local (
    .act      (lq_valid),
    .op       (lq_op),
    .peer_has (lq_peer_has),
    .cur      (l_cur),
    .cur_res  (l_res),
    .nxt      (l_nxt),
    .nxt_res  (l_res_n),
    .bc       (l_bc),
    .bc_kind  (l_bc_kind),
    .wb       (l_wb),
    .sc_ok    (l_sc_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_state <= '0;
      rsp_sc_ok <= 1'b0;
      bc_req    <= 1'b0;
      bc_kind   <= 1'b0;
      bc_idx    <= '0;
      sup_req   <= 1'b0;
      sup_idx   <= '0;
      wb_req    <= 1'b0;
      wb_idx    <= '0;
    end else begin
      rsp_valid <= lq_valid;
      rsp_state <= lq_valid ? l_nxt : 3'b000;
      rsp_sc_ok <= l_sc_ok;
      bc_req    <= l_bc;
      bc_kind   <= l_bc && l_bc_kind;
      bc_idx    <= l_bc ? lq_idx : '0;
      sup_req   <= s_sup;
      sup_idx   <= s_sup ? sn_idx : '0;
      wb_req    <= l_wb;
      wb_idx    <= l_wb ? lq_idx : '0;
    end
  end

  assert_wb_from_evict_R5: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> $past(lq_valid && lq_op == OP_EVICT));
  assert_sup_from_snoop_R6: assert property (@(posedge clk) disable iff (rst)
    sup_req |-> $past(sn_valid));
  assert_bc_from_local_R4: assert property (@(posedge clk) disable iff (rst)
    bc_req |-> $past(lq_valid && lq_op != OP_EVICT));
  assert_sc_ok_from_sc_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_sc_ok |-> $past(lq_valid && lq_op == OP_SC));
  assert_rsp_encoding_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_state[2]) |-> (rsp_state[1:0] == 2'b00));
  assert_rsp_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lq_valid));
endmodule

// File: tb/test_moesi_coherence_ctrl.sv
module test_moesi_coherence_ctrl;
  localparam int NL = 16;
  localparam int IW = $clog2(NL);

  typedef enum int {MI, MS, ME, MO, MM} mst_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lq_valid = 1'b0, lq_peer_has = 1'b0, sn_valid = 1'b0, sn_op = 1'b0;
  logic [2:0] lq_op = '0;
  logic [IW-1:0] lq_idx = '0, sn_idx = '0;
  logic rsp_valid, rsp_sc_ok, bc_req, bc_kind, sup_req, wb_req;
  logic [2:0] rsp_state;
  logic [IW-1:0] bc_idx, sup_idx, wb_idx;

  always #5 clk = ~clk;

  moesi_coherence_ctrl #(.N_LINES(NL)) i_moesi_coherence_ctrl (
    .clk(clk), .rst(rst),
    .lq_valid(lq_valid), .lq_op(lq_op), .lq_idx(lq_idx), .lq_peer_has(lq_peer_has),
    .sn_valid(sn_valid), .sn_op(sn_op), .sn_idx(sn_idx),
    .rsp_valid(rsp_valid), .rsp_state(rsp_state), .rsp_sc_ok(rsp_sc_ok),
    .bc_req(bc_req), .bc_kind(bc_kind), .bc_idx(bc_idx),
    .sup_req(sup_req), .sup_idx(sup_idx), .wb_req(wb_req), .wb_idx(wb_idx)
  );

  mst_t m [NL];
  bit   mres [NL];
  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  logic [2:0] e_state;
  logic e_rv, e_sc, e_bc, e_bk, e_sup, e_wb;
  int e_bi, e_si, e_wi;

  function automatic logic [2:0] enc(mst_t s);
    case (s)
      MM: return 3'b110;
      MO: return 3'b111;
      ME: return 3'b100;
      MS: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string f, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, f, act, exp);
    end
  endtask

  task automatic compare();
    chk("rsp_valid", int'(rsp_valid), int'(e_rv));
    chk("rsp_state", int'(rsp_state), int'(e_state));
    chk("rsp_sc_ok", int'(rsp_sc_ok), int'(e_sc));
    chk("bc", int'({bc_req, bc_kind}), int'({e_bc, e_bk}));
    if (e_bc) chk("bc_idx", int'(bc_idx), e_bi);
    chk("sup_req", int'(sup_req), int'(e_sup));
    if (e_sup) chk("sup_idx", int'(sup_idx), e_si);
    chk("wb_req", int'(wb_req), int'(e_wb));
    if (e_wb) chk("wb_idx", int'(wb_idx), e_wi);
  endtask

  task automatic clear_exp();
    e_rv = 0; e_state = 0; e_sc = 0; e_bc = 0; e_bk = 0; e_sup = 0; e_wb = 0;
    e_bi = 0; e_si = 0; e_wi = 0;
  endtask

  // one cycle: check the previous results, then drive and model the next request
  task automatic cyc(logic lv, logic [2:0] op, int li, logic ph, logic sv, logic so, int si);
    mst_t st;
    @(negedge clk);
    compare();
    lq_valid = lv; lq_op = op; lq_idx = IW'(li); lq_peer_has = ph;
    sn_valid = sv; sn_op = so; sn_idx = IW'(si);
    clear_exp();
    if (sv) begin
      st = m[si];
      if (so == 1'b0) begin
        if (st == MM) begin m[si] = MO; e_sup = 1; end
        else if (st == MO) e_sup = 1;
        else if (st == ME) m[si] = MS;
      end else if (st != MI) begin
        e_sup = (st == MM || st == MO);
        m[si] = MI; mres[si] = 0;
      end
      e_si = si;
    end
    if (lv) begin
      st = m[li];
      case (op)
        3'd0, 3'd2: begin
          if (st == MI) begin m[li] = ph ? MS : ME; e_bc = 1; e_bk = 0; end
          if (op == 3'd2) mres[li] = 1;
        end
        3'd1: begin
          if (!(st == ME || st == MM)) begin e_bc = 1; e_bk = 1; end
          m[li] = MM;
        end
        3'd3: begin
          if (st != MI && mres[li]) begin
            e_sc = 1;
            if (st == MS || st == MO) begin e_bc = 1; e_bk = 1; end
            m[li] = MM; mres[li] = 0;
          end
        end
        3'd4: begin
          e_wb = (st == MM || st == MO);
          m[li] = MI; mres[li] = 0;
        end
        default: ;
      endcase
      e_rv = 1; e_state = enc(m[li]); e_bi = li; e_wi = li;
    end
  endtask

  task automatic loc(logic [2:0] op, int li, logic ph = 0);
    cyc(1, op, li, ph, 0, 0, 0);
  endtask
  task automatic snp(logic so, int si);
    cyc(0, 0, 0, 0, 1, so, si);
  endtask

  initial begin
    clear_exp();
    for (int i = 0; i < NL; i++) begin m[i] = MI; mres[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle outputs low, every line invalid and unreserved
    cyc(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < NL; i++) loc(3'd3, i);
    tag = "R2";
    loc(3'd0, 0, 0); loc(3'd0, 1, 1); loc(3'd0, 0, 1); loc(3'd2, 2, 0); loc(3'd2, 11, 1);
    tag = "R3";
    loc(3'd1, 0); loc(3'd1, 0);
    tag = "R4";
    loc(3'd1, 1); loc(3'd1, 3); snp(0, 3); loc(3'd1, 3);
    tag = "R6";
    snp(0, 0); snp(0, 0); loc(3'd2, 4); snp(0, 4); snp(0, 4); snp(0, 12);
    tag = "R8";
    loc(3'd3, 4); loc(3'd3, 4); loc(3'd2, 5); loc(3'd3, 5); loc(3'd3, 6);
    loc(3'd2, 13); loc(3'd1, 13); snp(0, 13); loc(3'd3, 13); loc(3'd3, 11);
    tag = "R7";
    loc(3'd2, 7); snp(1, 7); loc(3'd3, 7); snp(1, 0); snp(1, 14); snp(1, 11);
    tag = "R5";
    loc(3'd4, 3); loc(3'd0, 8); loc(3'd4, 8); loc(3'd4, 8);
    loc(3'd0, 9); loc(3'd1, 9); snp(0, 9); loc(3'd4, 9); loc(3'd0, 9, 1); loc(3'd4, 9);
    tag = "R11";
    loc(3'd2, 10); cyc(1, 3'd3, 10, 0, 1, 1, 10);
    loc(3'd1, 10); cyc(1, 3'd1, 10, 0, 1, 0, 10);
    cyc(1, 3'd0, 10, 1, 1, 1, 10);
    tag = "R12";
    loc(3'd5, 10); loc(3'd6, 10); loc(3'd7, 2); loc(3'd7, 15);
    tag = "R9 R10";
    for (int k = 0; k < 3000; k++)
      cyc(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), $urandom_range(0, 5),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
          $urandom_range(0, 5));
    cyc(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule